// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the 15-bit instruction fetch address of a small sequencing core. It also owns a 7-bit upper-address latch that software writes through a dedicated port. In each cycle it chooses the next fetch address from the decoded action presented by the instruction decoder. That address is either the incremented PC or one of several loads. For some loads the upper PC bits are merged from the latch, and for others they come out of a full 15-bit addition.

The upper PC bits are never written directly. A jump, a call or a write to the low PC byte takes them from the latch. The merge differs by load type: a jump or call takes only the top four latch bits, while a low-byte write or a computed call takes all seven. The two relative branches add PC+1 and an offset across the full width. One branch takes the 8-bit working register as an unsigned offset. The other takes a 9-bit operand as a signed offset.

For calls and for interrupt vectoring, the block raises a push strobe and presents PC+1 as the return address for an external stack.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `lat_o` read 0 and `push_o` is 0. This reset wins over every other request.
- R2: Action code 0 (sequential) and the unused code 7 make the next PC equal PC+1 modulo 2^15, so 0x7FFF is followed by 0x0000.
- R3: Action code 1 (low-byte write) makes the next PC equal {latch, `pcl_wdata_i`}. The latch value used is the one held before any latch write in the same cycle.
- R4: Action codes 2 (jump) and 3 (call) load next PC bits 10:0 from `opnd_i[10:0]` and bits 14:11 from latch bits 6:3.
- R5: Action code 4 (computed call) makes the next PC equal {latch, `wreg_i`}.
- R6: Action code 5 (register branch) makes the next PC equal PC + 1 + `wreg_i`, with `wreg_i` taken as unsigned. The sum wraps modulo 2^15.
- R7: Action code 6 (relative branch) makes the next PC equal PC + 1 + `opnd_i[8:0]`, with the operand taken as two's-complement. The sum wraps modulo 2^15 and may cross 256-word blocks.
- R8: `push_o` is 1 in the same cycle as action code 3, action code 4 or an interrupt request, and 0 otherwise. While `push_o` is 1, `ret_addr_o` equals `pc_o` + 1.
- R9: `irq_vec_i` makes the next PC equal the parameter `VEC_ADDR` (default 0x0004), whatever action code is present.
- R10: The latch changes only on a clock edge with `lat_we_i` high, and then takes `lat_wdata_i`. PC loads never alter it, and `lat_o` shows its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| act_i | input | 3 | Decoded PC action code |
| irq_vec_i | input | 1 | Interrupt vectoring request |
| opnd_i | input | 11 | Instruction operand (jump target or signed branch offset) |
| wreg_i | input | 8 | Working register value |
| pcl_wdata_i | input | 8 | Result written to the low PC byte |
| lat_we_i | input | 1 | Upper-address latch write enable |
| lat_wdata_i | input | 7 | Upper-address latch write data |
| pc_o | output | 15 | Current program counter |
| lat_o | output | 7 | Current upper-address latch |
| ret_addr_o | output | 15 | Return address to push |
| push_o | output | 1 | Push strobe for the external stack |

## Verification
A corrupted PC register appears on `pc_o` one edge after the faulty load, and every following increment carries the error. A wrongly merged latch field shows up only in the bits that the load in question takes from the latch, so jumps and low-byte writes are run under a latch value whose top four and bottom three bits differ. Errors in the branch adders show up only when a carry leaves the low byte or the full width, so offsets that cross a 256-word block and offsets that wrap past zero are applied. A corrupted latch stays hidden until the next merging load, so the latch is read back on `lat_o` straight after each load that must leave it alone.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

  typedef enum logic [2:0] {
    ACT_SEQ   = 3'd0,
    ACT_PCLWR = 3'd1,
    ACT_JUMP  = 3'd2,
    ACT_CALL  = 3'd3,
    ACT_CALLW = 3'd4,
    ACT_BRW   = 3'd5,
    ACT_BRA   = 3'd6,
    ACT_RSVD  = 3'd7
  } pc_act_e;

endpackage

// File: rtl/pcnu_hilatch.sv
module pcnu_hilatch #(
  parameter int LAT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [LAT_W-1:0] wdata_i,
  output logic [LAT_W-1:0] lat_o
);

  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] lat_d;

  always_comb begin
    lat_d = lat_q;
    if (we_i) lat_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign lat_o = lat_q;

endmodule

// File: rtl/pcnu_target.sv
module pcnu_target
  import pcnu_pkg::*;
#(
  parameter int          PC_W     = 15,
  parameter int          DATA_W   = 8,
  parameter int          OPND_W   = 11,
  parameter int          BOFS_W   = 9,
  parameter logic [14:0] VEC_ADDR = 15'h0004
) (
  input  logic [PC_W-1:0]        pc_i,
  input  logic [PC_W-DATA_W-1:0] lat_i,
  input  pc_act_e                act_i,
  input  logic                   irq_i,
  input  logic                   rst_ok_i,
  input  logic [OPND_W-1:0]      opnd_i,
  input  logic [DATA_W-1:0]      wreg_i,
  input  logic [DATA_W-1:0]      pcl_wdata_i,
  output logic [PC_W-1:0]        nxt_o,
  output logic [PC_W-1:0]        ret_o,
  output logic                   push_o
);

  localparam int LAT_W  = PC_W - DATA_W;
  localparam int JHI_W  = PC_W - OPND_W;
  localparam int ZEXT_W = PC_W - DATA_W;
  localparam int SEXT_W = PC_W - BOFS_W;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] brw_sum;
  logic [PC_W-1:0] bra_sum;
  logic [PC_W-1:0] jmp_tgt;
  logic [PC_W-1:0] pcl_tgt;
  logic [PC_W-1:0] cw_tgt;
  logic [PC_W-1:0] bofs_ext;

  assign pc_inc   = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
  assign bofs_ext = {{SEXT_W{opnd_i[BOFS_W-1]}}, opnd_i[BOFS_W-1:0]};
  assign brw_sum  = pc_inc + {{ZEXT_W{1'b0}}, wreg_i};
  assign bra_sum  = pc_inc + bofs_ext;
  assign jmp_tgt  = {lat_i[LAT_W-1 -: JHI_W], opnd_i};
  assign pcl_tgt  = {lat_i, pcl_wdata_i};
  assign cw_tgt   = {lat_i, wreg_i};

  always_comb begin
    if (irq_i) begin
      nxt_o = VEC_ADDR[PC_W-1:0];
    end else begin
      unique case (act_i)
        ACT_PCLWR:          nxt_o = pcl_tgt;
        ACT_JUMP, ACT_CALL: nxt_o = jmp_tgt;
        ACT_CALLW:          nxt_o = cw_tgt;
        ACT_BRW:            nxt_o = brw_sum;
        ACT_BRA:            nxt_o = bra_sum;
        default:            nxt_o = pc_inc;
      endcase
    end
  end

  assign push_o = rst_ok_i & (irq_i | (act_i == ACT_CALL) | (act_i == ACT_CALLW));
  assign ret_o  = pc_inc;

endmodule

// File: rtl/pcnu_pcreg.sv
module pcnu_pcreg #(
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc_d_i,
  output logic [PC_W-1:0] pc_q_o
);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d_i;
  end

  assign pc_q_o = pc_q;

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int          PC_W     = 15,
  parameter int          DATA_W   = 8,
  parameter int          OPND_W   = 11,
  parameter int          BOFS_W   = 9,
  parameter logic [14:0] VEC_ADDR = 15'h0004
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             act_i,
  input  logic                   irq_vec_i,
  input  logic [OPND_W-1:0]      opnd_i,
  input  logic [DATA_W-1:0]      wreg_i,
  input  logic [DATA_W-1:0]      pcl_wdata_i,
  input  logic                   lat_we_i,
  input  logic [PC_W-DATA_W-1:0] lat_wdata_i,
  output logic [PC_W-1:0]        pc_o,
  output logic [PC_W-DATA_W-1:0] lat_o,
  output logic [PC_W-1:0]        ret_addr_o,
  output logic                   push_o
);

  localparam int LAT_W = PC_W - DATA_W;

  logic [PC_W-1:0]  pc_cur;
  logic [PC_W-1:0]  pc_nxt;
  logic [LAT_W-1:0] lat_cur;
  pc_act_e          act_dec;

  assign act_dec = pc_act_e'(act_i);

  pcnu_hilatch #(.LAT_W(LAT_W)) u_hilatch (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (lat_we_i),
    .wdata_i (lat_wdata_i),
    .lat_o   (lat_cur)
  );

  pcnu_target #(
    .PC_W(PC_W), .DATA_W(DATA_W), .OPND_W(OPND_W),
    .BOFS_W(BOFS_W), .VEC_ADDR(VEC_ADDR)
  ) u_target (
    .pc_i        (pc_cur),
    .lat_i       (lat_cur),
    .act_i       (act_dec),
    .irq_i       (irq_vec_i),
    .rst_ok_i    (rst_n),
    .opnd_i      (opnd_i),
    .wreg_i      (wreg_i),
    .pcl_wdata_i (pcl_wdata_i),
    .nxt_o       (pc_nxt),
    .ret_o       (ret_addr_o),
    .push_o      (push_o)
  );

  pcnu_pcreg #(.PC_W(PC_W)) u_pcreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_d_i (pc_nxt),
    .pc_q_o (pc_cur)
  );

  assign pc_o  = pc_cur;
  assign lat_o = lat_cur;

endmodule

// File: rtl/pcnu_checker.sv
module pcnu_checker #(
  parameter int          PC_W     = 15,
  parameter int          DATA_W   = 8,
  parameter int          OPND_W   = 11,
  parameter int          BOFS_W   = 9,
  parameter logic [14:0] VEC_ADDR = 15'h0004
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             act_i,
  input logic                   irq_vec_i,
  input logic [OPND_W-1:0]      opnd_i,
  input logic [DATA_W-1:0]      wreg_i,
  input logic [DATA_W-1:0]      pcl_wdata_i,
  input logic                   lat_we_i,
  input logic [PC_W-DATA_W-1:0] lat_wdata_i,
  input logic [PC_W-1:0]        pc_o,
  input logic [PC_W-DATA_W-1:0] lat_o,
  input logic [PC_W-1:0]        ret_addr_o,
  input logic                   push_o
);

  localparam int LAT_W = PC_W - DATA_W;
  localparam int JHI_W = PC_W - OPND_W;

  logic [PC_W-1:0] bofs_sx;
  assign bofs_sx = {{(PC_W-BOFS_W){opnd_i[BOFS_W-1]}}, opnd_i[BOFS_W-1:0]};

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_vec_i && (act_i == 3'd0 || act_i == 3'd7)) |=> pc_o == $past(pc_o) + 15'd1); // R2

  AST_PCL_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_vec_i && act_i == 3'd1) |=> pc_o == {$past(lat_o), $past(pcl_wdata_i)}); // R3

  AST_JUMP_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_vec_i && (act_i == 3'd2 || act_i == 3'd3)) |=>
      (pc_o[OPND_W-1:0] == $past(opnd_i) && pc_o[PC_W-1 -: JHI_W] == $past(lat_o[LAT_W-1 -: JHI_W]))); // R4

  AST_CALLW_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_vec_i && act_i == 3'd4) |=> pc_o == {$past(lat_o), $past(wreg_i)}); // R5

  AST_BRW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_vec_i && act_i == 3'd5) |=> pc_o == $past(pc_o) + 15'd1 + {7'd0, $past(wreg_i)}); // R6

  AST_BRA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_vec_i && act_i == 3'd6) |=> pc_o == $past(pc_o) + 15'd1 + $past(bofs_sx)); // R7

  AST_PUSH_RET: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> ret_addr_o == pc_o + 15'd1); // R8

  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    push_o == (irq_vec_i || act_i == 3'd3 || act_i == 3'd4)); // R8

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec_i |=> pc_o == VEC_ADDR[PC_W-1:0]); // R9

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_we_i |=> $stable(lat_o)); // R10

  AST_LAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we_i |=> lat_o == $past(lat_wdata_i)); // R10

endmodule

bind pc_next_unit pcnu_checker #(
  .PC_W(PC_W), .DATA_W(DATA_W), .OPND_W(OPND_W),
  .BOFS_W(BOFS_W), .VEC_ADDR(VEC_ADDR)
) u_pcnu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_i       (act_i),
  .irq_vec_i   (irq_vec_i),
  .opnd_i      (opnd_i),
  .wreg_i      (wreg_i),
  .pcl_wdata_i (pcl_wdata_i),
  .lat_we_i    (lat_we_i),
  .lat_wdata_i (lat_wdata_i),
  .pc_o        (pc_o),
  .lat_o       (lat_o),
  .ret_addr_o  (ret_addr_o),
  .push_o      (push_o)
);

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [2:0]  act;
    logic        irq;
    logic [10:0] opnd;
    logic [7:0]  wreg;
    logic [7:0]  pcl;
    logic        push;
    logic [14:0] ret;
    logic [14:0] pc;
  } vec_t;

  // Starting point: pc = 0x0001, latch = 0x15
  localparam vec_t TBL [NVEC] = '{
    '{3'd0, 1'b0, 11'h000, 8'h00, 8'h00, 1'b0, 15'h0000, 15'h0002}, // R2 step
    '{3'd1, 1'b0, 11'h000, 8'h00, 8'h3C, 1'b0, 15'h0000, 15'h153C}, // R3
    '{3'd5, 1'b0, 11'h000, 8'hF0, 8'h00, 1'b0, 15'h0000, 15'h162D}, // R6 crosses block
    '{3'd6, 1'b0, 11'h1FE, 8'h00, 8'h00, 1'b0, 15'h0000, 15'h162C}, // R7 negative
    '{3'd6, 1'b0, 11'h0FF, 8'h00, 8'h00, 1'b0, 15'h0000, 15'h172C}, // R7 positive
    '{3'd2, 1'b0, 11'h5A3, 8'h00, 8'h00, 1'b0, 15'h0000, 15'h15A3}, // R4 jump
    '{3'd3, 1'b0, 11'h7FF, 8'h00, 8'h00, 1'b1, 15'h15A4, 15'h17FF}, // R4 R8 call
    '{3'd4, 1'b0, 11'h000, 8'h81, 8'h00, 1'b1, 15'h1800, 15'h1581}, // R5 R8
    '{3'd0, 1'b1, 11'h000, 8'h00, 8'h00, 1'b1, 15'h1582, 15'h0004}, // R9 R8
    '{3'd5, 1'b1, 11'h000, 8'h44, 8'h00, 1'b1, 15'h0005, 15'h0004}, // R9 priority
    '{3'd7, 1'b0, 11'h000, 8'h00, 8'h00, 1'b0, 15'h0000, 15'h0005}  // R2 code 7
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  act_i;
  logic        irq_vec_i;
  logic [10:0] opnd_i;
  logic [7:0]  wreg_i;
  logic [7:0]  pcl_wdata_i;
  logic        lat_we_i;
  logic [6:0]  lat_wdata_i;
  logic [14:0] pc_o;
  logic [6:0]  lat_o;
  logic [14:0] ret_addr_o;
  logic        push_o;

  int checks;
  int fails;
  bit done;

  pc_next_unit u_pc_next_unit (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .irq_vec_i(irq_vec_i),
    .opnd_i(opnd_i), .wreg_i(wreg_i), .pcl_wdata_i(pcl_wdata_i),
    .lat_we_i(lat_we_i), .lat_wdata_i(lat_wdata_i),
    .pc_o(pc_o), .lat_o(lat_o), .ret_addr_o(ret_addr_o), .push_o(push_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] a, input logic irq, input logic [10:0] op,
                       input logic [7:0] w, input logic [7:0] p,
                       input logic lwe, input logic [6:0] lwd);
    act_i = a; irq_vec_i = irq; opnd_i = op; wreg_i = w;
    pcl_wdata_i = p; lat_we_i = lwe; lat_wdata_i = lwd;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b1;
    drive(3'd3, 1'b0, 11'h0, 8'h0, 8'h0, 1'b0, 7'h0);
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk("R1 pc in reset", 32'(pc_o), 32'h0);
    chk("R1 latch in reset", 32'(lat_o), 32'h0);
    chk("R1 no push in reset", 32'(push_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 1'b0, 11'h0, 8'h0, 8'h0, 1'b1, 7'h15);
    @(negedge clk);
    chk("R10 latch write", 32'(lat_o), 32'h15);
    chk("R2 first step", 32'(pc_o), 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i].act, TBL[i].irq, TBL[i].opnd, TBL[i].wreg, TBL[i].pcl, 1'b0, 7'h0);
      #2;
      chk("R8 push strobe", 32'(push_o), 32'(TBL[i].push));
      if (TBL[i].push) chk("R8 return address", 32'(ret_addr_o), 32'(TBL[i].ret));
      @(negedge clk);
      chk("R2-table next pc", 32'(pc_o), 32'(TBL[i].pc));
      chk("R10 latch unchanged", 32'(lat_o), 32'h15);
    end

    // latch write alongside sequential step
    drive(3'd0, 1'b0, 11'h0, 8'h0, 8'h0, 1'b1, 7'h7F);
    @(negedge clk);
    chk("R10 latch write 7F", 32'(lat_o), 32'h7F);
    chk("R2 step", 32'(pc_o), 32'h6);
    // low-byte write to top of space
    drive(3'd1, 1'b0, 11'h0, 8'h0, 8'hFF, 1'b0, 7'h0);
    @(negedge clk);
    chk("R3 top address", 32'(pc_o), 32'h7FFF);
    // increment wraps
    drive(3'd0, 1'b0, 11'h0, 8'h0, 8'h0, 1'b0, 7'h0);
    @(negedge clk);
    chk("R2 wrap to zero", 32'(pc_o), 32'h0);
    // signed branch wraps below zero
    drive(3'd6, 1'b0, 11'h100, 8'h0, 8'h0, 1'b0, 7'h0);
    @(negedge clk);
    chk("R7 wrap below zero", 32'(pc_o), 32'h7F01);
    // low-byte write uses latch before same-cycle write
    drive(3'd1, 1'b0, 11'h0, 8'h0, 8'h10, 1'b1, 7'h01);
    @(negedge clk);
    chk("R3 old latch used", 32'(pc_o), 32'h7F10);
    chk("R10 latch written", 32'(lat_o), 32'h01);
    // call with latch top bits zero
    drive(3'd3, 1'b0, 11'h000, 8'h0, 8'h0, 1'b0, 7'h0);
    #2;
    chk("R8 call return", 32'(ret_addr_o), 32'h7F11);
    @(negedge clk);
    chk("R4 call top bits from latch", 32'(pc_o), 32'h0);
    chk("R10 latch kept after call", 32'(lat_o), 32'h01);
    // advance then reset mid-run with a call pending
    drive(3'd0, 1'b0, 11'h0, 8'h0, 8'h0, 1'b0, 7'h0);
    @(negedge clk);
    drive(3'd3, 1'b1, 11'h7FF, 8'h0, 8'h0, 1'b1, 7'h33);
    rst_n = 1'b0;
    #2;
    chk("R1 pc cleared mid-run", 32'(pc_o), 32'h0);
    chk("R1 push suppressed", 32'(push_o), 32'h0);
    @(negedge clk);
    chk("R1 latch cleared", 32'(lat_o), 32'h0);
    chk("R1 pc held", 32'(pc_o), 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule